// File: doc/BRIEF.md
# Multiplexed-Address DRAM Device Emulator

This block plays the memory side of a 16-bit asynchronous DRAM with a shared row/column address bus, so that a DRAM controller can be exercised against it in a clocked simulation. On every clock edge it samples the row strobe, the two byte column strobes, write enable, output enable and the 9-bit address. From these samples it recognises row opens, column selects, per-byte writes and reads, and refresh cycles. Data lives in a small array whose depth is set by parameters.

The data bus is split into a write path and a read path, and each byte has its own output-enable bit. A byte lane counts as high-impedance whenever its enable bit is low. A sticky three-bit error vector reports three faults: a row strobe held low for too short a time, a precharge that is too short, and a column access made during power-up initialisation. Timing effects finer than one clock period are outside the model.

Top module: `dram_strobe_emu`

## Requirements
- R1: On the clock edge that first samples the row strobe low while both column strobes were high, the address is taken as the row. The first column strobe sampled low then selects the column from the address present at that moment. A read returns the word stored at that row and column.
- R2: The column phase starts when the first byte strobe falls and lasts until both byte strobes are high again. A second byte strobe falling inside the phase does not take a new column address. Neither does a byte strobe that rises and falls again inside the phase.
- R3: A byte is written on the later of two edges: its own strobe falling, or write enable falling. The write uses the data on dq_i at that edge and needs the other signal already low. Bytes whose strobe is high keep their contents. Byte 0 is dq[7:0] under lcas_ni, and byte 1 is dq[15:8] under ucas_ni.
- R4: dq_oe_o[b] is 1 only while a memory cycle is open, write enable is high, output enable is low and byte b's strobe is low. Otherwise the lane is 0 (high-impedance).
- R5: A column strobe already low when the row strobe falls starts a refresh. The address is ignored, nothing is written or driven, and ref_row_o (the 9-bit row counter, 0 after reset) increments modulo 512.
- R6: A memory cycle closes only when the row strobe and both column strobes are all high. While the row strobe is high but a column strobe is still low, the read output stays driven. After the cycle closes, a column strobe on its own drives nothing.
- R7: Row and column address bits at or above ROW_BITS and COL_BITS are ignored, so addresses that differ only in those bits reach the same word.
- R8: err_o[0] is set when the row strobe rises after fewer than T_RAS_MIN consecutive low samples.
- R9: err_o[1] is set when the row strobe falls after fewer than T_RP_MIN consecutive high samples.
- R10: err_o[2] is set for a column access inside any of the first INIT_CYCLES row cycles after reset. Refresh cycles count as row cycles.
- R11: Reset clears the errors, the refresh counter and all drive enables. Error bits stay set until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ras_ni | input | 1 | Row strobe, active low |
| lcas_ni | input | 1 | Low-byte column strobe, active low |
| ucas_ni | input | 1 | High-byte column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| addr_i | input | 9 | Multiplexed row/column address |
| dq_i | input | 16 | Write data from the controller |
| dq_o | output | 16 | Read data (zero in lanes that are not driven) |
| dq_oe_o | output | 2 | Per-byte drive enable |
| ref_row_o | output | 9 | Next row the refresh counter will supply |
| err_o | output | 3 | Sticky faults: [0] short row active, [1] short precharge, [2] access during init |

## Verification
Two pairs of functions can occur in the same cycle. The first pair is a refresh and an open read. It is provoked by raising the row strobe during a read and lowering it again while the column strobes stay low. The bench checks that the refresh counter advances and that the read word keeps being driven, unchanged. The second pair is a write and a column-phase start. It is provoked by lowering write enable before the strobe, and by lowering it after the strobe in a read-then-write cycle. A read-back shows that exactly one write landed, at the column latched when the phase began.

// File: rtl/dram_emu_pkg.sv
package dram_emu_pkg;
  localparam int unsigned NUM_ERR = 3;

  typedef enum logic [1:0] {
    ERR_RAS_SHORT = 2'd0,
    ERR_PRE_SHORT = 2'd1,
    ERR_EARLY_ACC = 2'd2
  } err_idx_e;

  typedef struct packed {
    logic row_fall;
    logic row_latch;
    logic refresh;
    logic col_latch;
    logic ras_rise;
    logic cycle_end;
  } strobe_ev_t;
endpackage

// File: rtl/dram_strobe_decode.sv
module dram_strobe_decode
  import dram_emu_pkg::*;
#(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned NB     = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ras_ni,
  input  logic [NB-1:0]     cas_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output strobe_ev_t        ev_o,
  output logic              active_o,
  output logic              refresh_o,
  output logic [ADDR_W-1:0] row_o,
  output logic [ADDR_W-1:0] col_o,
  output logic [ADDR_W-1:0] ref_cnt_o,
  output logic [NB-1:0]     byte_fall_o,
  output logic              we_fall_o
);
  logic              ras_q, we_q, active_q, ref_q;
  logic [NB-1:0]     cas_q;
  logic [ADDR_W-1:0] row_q, col_q, ref_cnt_q;
  logic              cas_any_n, cas_any_q;
  logic              row_fall, refresh, row_latch, col_latch, ras_rise, cycle_end;

  // combined strobe: low while any byte strobe is low
  assign cas_any_n = &cas_ni;
  assign cas_any_q = &cas_q;

  assign row_fall  = ras_q & ~ras_ni;
  assign refresh   = row_fall & ~cas_any_q;
  assign row_latch = row_fall & cas_any_q;
  assign col_latch = cas_any_q & ~cas_any_n & ~ras_ni & active_q & ~ref_q;
  assign ras_rise  = ~ras_q & ras_ni;
  assign cycle_end = ras_ni & cas_any_n;

  assign ev_o = '{row_fall:  row_fall,
                  row_latch: row_latch,
                  refresh:   refresh,
                  col_latch: col_latch,
                  ras_rise:  ras_rise,
                  cycle_end: cycle_end};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ras_q     <= 1'b1;
      cas_q     <= '1;
      we_q      <= 1'b1;
      active_q  <= 1'b0;
      ref_q     <= 1'b0;
      row_q     <= '0;
      col_q     <= '0;
      ref_cnt_q <= '0;
    end else begin
      ras_q <= ras_ni;
      cas_q <= cas_ni;
      we_q  <= we_ni;
      if (refresh) begin
        ref_q     <= 1'b1;
        ref_cnt_q <= ref_cnt_q + 1'b1;
      end
      if (row_latch) begin
        active_q <= 1'b1;
        row_q    <= addr_i;
      end
      if (col_latch) col_q <= addr_i;
      if (cycle_end) begin
        active_q <= 1'b0;
        ref_q    <= 1'b0;
      end
    end
  end

  assign active_o    = active_q;
  assign refresh_o   = ref_q;
  assign row_o       = row_q;
  assign col_o       = col_latch ? addr_i : col_q;
  assign ref_cnt_o   = ref_cnt_q;
  assign byte_fall_o = cas_q & ~cas_ni;
  assign we_fall_o   = we_q & ~we_ni;

  AST_CYCLE_CLOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ras_ni && (&cas_ni)) |=> (!active_q && !ref_q)); // R6
  AST_REFRESH_KEEPS_ROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh |=> $stable(row_q)); // R5
  AST_COL_HELD_IN_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cas_any_q && !cas_any_n) |=> $stable(col_q)); // R2
endmodule

// File: rtl/dram_timing_chk.sv
module dram_timing_chk
  import dram_emu_pkg::*;
#(
  parameter int unsigned T_RAS_MIN   = 4,
  parameter int unsigned T_RP_MIN    = 3,
  parameter int unsigned INIT_CYCLES = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ras_ni,
  input  strobe_ev_t         ev_i,
  output logic [NUM_ERR-1:0] err_o
);
  localparam int unsigned MAX_A = (T_RAS_MIN > T_RP_MIN) ? T_RAS_MIN : T_RP_MIN;
  localparam int unsigned MAX_V = (MAX_A > INIT_CYCLES + 1) ? MAX_A : INIT_CYCLES + 1;
  localparam int unsigned CNT_W = $clog2(MAX_V + 1);

  logic [CNT_W-1:0]   low_cnt_q, high_cnt_q, init_cnt_q;
  logic [NUM_ERR-1:0] err_q, err_set;

  always_comb begin
    err_set = '0;
    err_set[ERR_RAS_SHORT] = ev_i.ras_rise  && (low_cnt_q < CNT_W'(T_RAS_MIN));
    err_set[ERR_PRE_SHORT] = ev_i.row_fall  && (high_cnt_q < CNT_W'(T_RP_MIN));
    err_set[ERR_EARLY_ACC] = ev_i.col_latch && (init_cnt_q <= CNT_W'(INIT_CYCLES));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_cnt_q  <= '0;
      high_cnt_q <= CNT_W'(T_RP_MIN);
      init_cnt_q <= '0;
      err_q      <= '0;
    end else begin
      if (ev_i.row_fall) low_cnt_q <= CNT_W'(1);
      else if (!ras_ni && low_cnt_q < CNT_W'(T_RAS_MIN)) low_cnt_q <= low_cnt_q + 1'b1;
      if (ev_i.ras_rise) high_cnt_q <= CNT_W'(1);
      else if (ras_ni && high_cnt_q < CNT_W'(T_RP_MIN)) high_cnt_q <= high_cnt_q + 1'b1;
      if (ev_i.row_fall && init_cnt_q <= CNT_W'(INIT_CYCLES)) init_cnt_q <= init_cnt_q + 1'b1;
      err_q <= err_q | err_set;
    end
  end

  assign err_o = err_q;

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q & $past(err_q)) == $past(err_q)); // R11
  AST_INIT_SATURATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_cnt_q <= CNT_W'(INIT_CYCLES + 1)); // R10
endmodule

// File: rtl/dram_store.sv
module dram_store #(
  parameter int unsigned ADDR_W   = 9,
  parameter int unsigned ROW_BITS = 3,
  parameter int unsigned COL_BITS = 3,
  parameter int unsigned NB       = 2
) (
  input  logic              clk_i,
  input  logic [ADDR_W-1:0] row_i,
  input  logic [ADDR_W-1:0] col_i,
  input  logic [NB-1:0]     wr_be_i,
  input  logic [NB*8-1:0]   wdata_i,
  output logic [NB*8-1:0]   rdata_o
);
  localparam int unsigned IDX_W = ROW_BITS + COL_BITS;
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [NB*8-1:0] mem_q [DEPTH];
  logic [IDX_W-1:0] idx;
  logic unused_hi;

  // upper address bits alias onto the same word
  assign idx       = {row_i[ROW_BITS-1:0], col_i[COL_BITS-1:0]};
  assign unused_hi = ^{row_i, col_i};

  always_ff @(posedge clk_i) begin
    for (int b = 0; b < NB; b++) begin
      if (wr_be_i[b]) mem_q[idx][b*8 +: 8] <= wdata_i[b*8 +: 8];
    end
  end

  assign rdata_o = mem_q[idx];
endmodule

// File: rtl/dram_strobe_emu.sv
module dram_strobe_emu
  import dram_emu_pkg::*;
#(
  parameter int unsigned ADDR_W      = 9,
  parameter int unsigned ROW_BITS    = 3,
  parameter int unsigned COL_BITS    = 3,
  parameter int unsigned T_RAS_MIN   = 4,
  parameter int unsigned T_RP_MIN    = 3,
  parameter int unsigned INIT_CYCLES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ras_ni,
  input  logic              lcas_ni,
  input  logic              ucas_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [15:0]       dq_i,
  output logic [15:0]       dq_o,
  output logic [1:0]        dq_oe_o,
  output logic [ADDR_W-1:0] ref_row_o,
  output logic [2:0]        err_o
);
  localparam int unsigned NB = 2;

  strobe_ev_t        ev;
  logic [NB-1:0]     cas_n, byte_fall, wr_be, rd_en;
  logic              we_fall, access_active, ref_active;
  logic [ADDR_W-1:0] row, col;
  logic [NB*8-1:0]   rdata;

  assign cas_n = {ucas_ni, lcas_ni};

  dram_strobe_decode #(.ADDR_W(ADDR_W), .NB(NB)) u_decode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ras_ni     (ras_ni),
    .cas_ni     (cas_n),
    .we_ni      (we_ni),
    .addr_i     (addr_i),
    .ev_o       (ev),
    .active_o   (access_active),
    .refresh_o  (ref_active),
    .row_o      (row),
    .col_o      (col),
    .ref_cnt_o  (ref_row_o),
    .byte_fall_o(byte_fall),
    .we_fall_o  (we_fall)
  );

  dram_timing_chk #(
    .T_RAS_MIN  (T_RAS_MIN),
    .T_RP_MIN   (T_RP_MIN),
    .INIT_CYCLES(INIT_CYCLES)
  ) u_timing (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ras_ni(ras_ni),
    .ev_i  (ev),
    .err_o (err_o)
  );

  generate
    for (genvar b = 0; b < NB; b++) begin : g_lane
      // write fires on whichever of strobe / enable falls last
      assign wr_be[b] = access_active & ~ref_active & ~we_ni & ~cas_n[b]
                      & (byte_fall[b] | we_fall);
      assign rd_en[b] = access_active & we_ni & ~oe_ni & ~cas_n[b];
      assign dq_o[b*8 +: 8] = rd_en[b] ? rdata[b*8 +: 8] : 8'h00;
    end
  endgenerate

  assign dq_oe_o = rd_en;

  dram_store #(
    .ADDR_W  (ADDR_W),
    .ROW_BITS(ROW_BITS),
    .COL_BITS(COL_BITS),
    .NB      (NB)
  ) u_store (
    .clk_i  (clk_i),
    .row_i  (row),
    .col_i  (col),
    .wr_be_i(wr_be),
    .wdata_i(dq_i),
    .rdata_o(rdata)
  );

  AST_NO_BUS_CLASH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|wr_be) |-> (dq_oe_o == '0)); // R4
  AST_REFRESH_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_active && !access_active) |-> (dq_oe_o == '0 && wr_be == '0)); // R5
  AST_WRITE_NEEDS_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|wr_be) |-> !ras_ni); // R3
endmodule

// File: tb/dram_strobe_emu_tb.sv
`timescale 1ns/1ps
module dram_strobe_emu_tb;
  localparam int RB = 3;
  localparam int CB = 3;
  localparam int NR = 1 << RB;
  localparam int NC = 1 << CB;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic ras_n = 1'b1, lcas_n = 1'b1, ucas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [8:0]  addr = '0;
  logic [15:0] dq_w = '0;
  logic [15:0] dq_o;
  logic [1:0]  dq_oe;
  logic [8:0]  ref_row;
  logic [2:0]  err;

  int n_checks = 0;
  int n_err = 0;
  bit done = 1'b0;
  int exp_ref = 0;
  logic [15:0] exp_mem [NR*NC];

  always #2.5 clk_i = ~clk_i;

  dram_strobe_emu u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .ras_ni(ras_n), .lcas_ni(lcas_n),
    .ucas_ni(ucas_n), .we_ni(we_n), .oe_ni(oe_n), .addr_i(addr),
    .dq_i(dq_w), .dq_o(dq_o), .dq_oe_o(dq_oe), .ref_row_o(ref_row), .err_o(err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk_i);
  endtask

  task automatic idle();
    ras_n = 1; lcas_n = 1; ucas_n = 1; we_n = 1; oe_n = 1;
  endtask

  task automatic do_reset();
    idle();
    rst_ni = 0;
    repeat (3) tick();
    rst_ni = 1;
    tick();
  endtask

  function automatic int ix(input int r, input int c);
    return (r % NR) * NC + (c % NC);
  endfunction

  function automatic logic [15:0] pat(input int r, input int c, input int k);
    return 16'((r * 4099 + c * 257 + k * 811 + 16'h1234) ^ (c << 11));
  endfunction

  task automatic wr(input int r, input int c, input logic [15:0] d, input logic [1:0] m);
    ras_n = 0; addr = 9'(r); tick();
    addr = 9'(c); lcas_n = ~m[0]; ucas_n = ~m[1]; we_n = 0; dq_w = d;
    tick(); tick(); tick();
    idle(); repeat (3) tick();
    if (m[0]) exp_mem[ix(r, c)][7:0]  = d[7:0];
    if (m[1]) exp_mem[ix(r, c)][15:8] = d[15:8];
  endtask

  task automatic rd(input int r, input int c, output logic [15:0] d, output logic [1:0] oe);
    ras_n = 0; addr = 9'(r); tick();
    addr = 9'(c); lcas_n = 0; ucas_n = 0; oe_n = 0;
    #1; d = dq_o; oe = dq_oe;
    tick(); tick(); tick();
    idle(); repeat (3) tick();
  endtask

  task automatic cbr(input logic [8:0] garbage);
    lcas_n = 0; tick();
    ras_n = 0; addr = garbage; we_n = 0; dq_w = 16'hDEAD; tick();
    tick(); tick(); tick();
    idle(); repeat (3) tick();
    exp_ref = (exp_ref + 1) % 512;
  endtask

  initial begin
    logic [15:0] d;
    logic [1:0]  oe;
    do_reset();
    check("R11 reset oe", 32'(dq_oe), 0);
    check("R11 reset err", 32'(err), 0);
    check("R11 reset refcnt", 32'(ref_row), 0);

    // access before init
    wr(1, 1, 16'hAAAA, 2'b11);
    check("R10 early access flag", 32'(err), 32'b100);
    repeat (5) tick();
    check("R11 sticky", 32'(err), 32'b100);
    do_reset();
    check("R11 reset clears err", 32'(err), 0);
    exp_ref = 0;

    for (int i = 0; i < 8; i++) begin
      cbr(9'(i * 37 + 5));
      check("R5 refresh counter", 32'(ref_row), 32'(exp_ref));
    end
    check("R10 refresh init no flag", 32'(err), 0);

    // full sweep
    for (int r = 0; r < NR; r++)
      for (int c = 0; c < NC; c++) wr(r, c, pat(r, c, 0), 2'b11);
    for (int r = 0; r < NR; r++)
      for (int c = 0; c < NC; c++) begin
        rd(r, c, d, oe);
        check("R1 sweep read", 32'(d), 32'(exp_mem[ix(r, c)]));
        check("R4 both lanes driven", 32'(oe), 32'b11);
      end

    // byte writes
    for (int r = 0; r < NR; r++)
      for (int c = 0; c < NC; c++) wr(r, c, pat(r, c, 1), ((r + c) % 2 == 0) ? 2'b01 : 2'b10);
    for (int r = 0; r < NR; r++)
      for (int c = 0; c < NC; c++) begin
        rd(r, c, d, oe);
        check("R3 byte write", 32'(d), 32'(exp_mem[ix(r, c)]));
      end

    // aliasing of upper address bits
    for (int r = 0; r < NR; r++) begin
      wr(r | 9'h1F8, (r + 3) | 9'h1F8, pat(r, 9, 2), 2'b11);
      rd(r, (r + 3) % NC, d, oe);
      check("R7 alias", 32'(d), 32'(pat(r, 9, 2)));
    end

    // refresh with we low, garbage address: no write
    cbr(9'h1FF);
    check("R5 refresh count", 32'(ref_row), 32'(exp_ref));
    rd(7, 7, d, oe);
    check("R5 refresh no write", 32'(d), 32'(exp_mem[ix(7, 7)]));

    // read then late write enable in one cycle
    ras_n = 0; addr = 9'd2; tick();
    addr = 9'd3; lcas_n = 0; ucas_n = 0; oe_n = 0; #1;
    check("R1 read before late write", 32'(dq_o), 32'(exp_mem[ix(2, 3)]));
    tick(); oe_n = 1; #1;
    check("R4 oe high no drive", 32'(dq_oe), 0);
    tick(); we_n = 0; dq_w = 16'h5AC3; #1;
    check("R4 we low no drive", 32'(dq_oe), 0);
    tick(); tick(); idle(); repeat (3) tick();
    exp_mem[ix(2, 3)] = 16'h5AC3;
    rd(2, 3, d, oe);
    check("R3 write at late we", 32'(d), 32'h5AC3);

    // we first, lower strobe later
    ras_n = 0; addr = 9'd5; tick();
    addr = 9'd1; we_n = 0; dq_w = 16'h9E71; tick();
    lcas_n = 0; tick(); tick(); tick();
    idle(); repeat (3) tick();
    exp_mem[ix(5, 1)][7:0] = 8'h71;
    rd(5, 1, d, oe);
    check("R3 write at late cas, lower only", 32'(d), 32'(exp_mem[ix(5, 1)]));

    // first-fall / last-rise, hidden refresh, cycle end
    ras_n = 0; addr = 9'd4; tick();
    addr = 9'd5; lcas_n = 0; oe_n = 0; #1;
    check("R4 lower only", 32'(dq_oe), 32'b01);
    tick(); addr = 9'd6; ucas_n = 0; #1;
    check("R2 no relatch on second strobe", 32'(dq_o), 32'(exp_mem[ix(4, 5)]));
    tick(); lcas_n = 1; #1;
    check("R2 phase held by upper", 32'(dq_oe), 32'b10);
    check("R2 upper data", 32'(dq_o), 32'(exp_mem[ix(4, 5)] & 16'hFF00));
    tick(); lcas_n = 0; #1;
    check("R2 refall no relatch", 32'(dq_o), 32'(exp_mem[ix(4, 5)]));
    tick(); ras_n = 1; #1;
    check("R6 open after ras rise", 32'(dq_oe), 32'b11);
    tick(); tick(); tick();
    check("R6 still driven", 32'(dq_o), 32'(exp_mem[ix(4, 5)]));
    ras_n = 0; addr = 9'h0AA; tick();
    exp_ref = (exp_ref + 1) % 512;
    check("R5 hidden refresh count", 32'(ref_row), 32'(exp_ref));
    check("R6 hidden refresh keeps data", 32'(dq_o), 32'(exp_mem[ix(4, 5)]));
    tick(); tick(); tick();
    idle(); tick();
    lcas_n = 0; oe_n = 0; #1;
    check("R6 closed cycle no drive", 32'(dq_oe), 0);
    idle(); repeat (3) tick();
    check("R8 R9 R10 no false error", 32'(err), 0);

    // short row active
    ras_n = 0; tick(); tick();
    ras_n = 1; tick();
    check("R8 short ras", 32'(err), 32'b001);
    tick(); tick();
    // short precharge
    ras_n = 0; repeat (4) tick();
    ras_n = 1; tick();
    ras_n = 0; tick();
    check("R9 short precharge", 32'(err), 32'b011);
    repeat (4) tick(); idle(); repeat (3) tick();

    // counter wrap
    do_reset();
    exp_ref = 0;
    for (int i = 0; i < 511; i++) cbr(9'(i));
    check("R5 refresh counter 511", 32'(ref_row), 511);
    cbr(9'h000);
    check("R5 refresh counter wrap", 32'(ref_row), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end
endmodule